// File: doc/BRIEF.md
# Partitioned Keyspace Candidate Enumerator

This block feeds an exhaustive-search engine with 7-character uppercase candidate keys, one per clock. At a start pulse it captures a linear start offset, a search width in bits and a character-set mode. It converts the offset into a mixed-radix counter with one digit per character position, then steps that counter, mapping each digit onto the active alphabet. Giving each unit a different offset and a smaller width splits one keyspace across several units. The same offset, read back from the position output after a stop, lets a halted search resume. A 14-character secret is handled as two 7-character halves searched independently, so one unit only ever handles one half.

Candidates go to an external hash pipeline of fixed latency `LAT`. A delay line of the same depth carries each candidate beside its result. Every returned hash is compared against a small table of enabled target values. A hit latches the originating candidate and the lowest matching target index in a sticky report, which stays until it is acknowledged.

Top module: `keyspace_enum`

## Requirements
- R1: After a start, the block spends 7 load cycles and then asserts `cand_vld_o` on consecutive clocks, one candidate each, while running and not stopped. Character k sits in `cand_o[8k+7:8k]`. Position 0 is the least significant digit and advances first.
- R2: With `mode_i`=1 (alphanumeric), the alphabet has 36 symbols in digit order: '0'..'9' are digits 0..9 and 'A'..'Z' are digits 10..35.
- R3: With `mode_i`=0 (printable), the alphabet has 69 symbols: 0x20..0x60 are digits 0..64 and 0x7B..0x7E are digits 65..68. A byte in 0x61..0x7A is never emitted.
- R4: The first candidate is the mixed-radix form of `offset_i`. If `offset_i` is at least radix^7, `done_o` rises with no candidate emitted.
- R5: A run emits exactly 2^min(`width_i`,56) candidates and then raises `done_o`. It stops earlier, after the all-maximum key, if the counter would wrap. `pos_o` always equals the offset plus the number of candidates issued.
- R6: While `stop_i` is high, no new candidate is issued and `pos_o` holds. On release, enumeration continues from the same position.
- R7: `hash_i` is taken `LAT` cycles after its candidate appeared on `cand_o`. It is compared with every target j in `tgt_i[56j+55:56j]` whose bit `tgt_en_i[j]` is set. A hit is reported on `match_vld_o` one cycle later, with `match_cand_o` naming the candidate that produced it.
- R8: When several targets hit in one cycle, `match_idx_o` reports the lowest index.
- R9: `match_vld_o` is sticky. It holds, with index and candidate unchanged, until `match_ack_i`. Hits that arrive while it is held are dropped.
- R10: A start pulse clears `done_o`. While done, no candidate is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load configuration and begin a run |
| stop_i | input | 1 | Freeze enumeration |
| offset_i | input | 56 | Linear start index |
| width_i | input | 6 | Log2 of candidates per run (clamped to 56) |
| mode_i | input | 1 | 1 alphanumeric, 0 printable |
| cand_vld_o | output | 1 | Candidate valid |
| cand_o | output | 56 | Candidate key, 7 bytes |
| hash_i | input | 56 | Hash result, LAT cycles after candidate |
| tgt_i | input | NTGT*56 | Target table, entry j at bits 56j+55:56j |
| tgt_en_i | input | NTGT | Per-target enable |
| match_ack_i | input | 1 | Clear the sticky match report |
| match_vld_o | output | 1 | Sticky match flag |
| match_idx_o | output | clog2(NTGT) | Lowest matching target index |
| match_cand_o | output | 56 | Candidate that produced the match |
| done_o | output | 1 | Run complete |
| pos_o | output | 56 | Linear position, usable as resume offset |

## Verification
A wrong digit or carry in the counter changes `cand_o` on the very next candidate, and the bench compares every emitted key with its own mixed-radix conversion of the linear index. A wrong count or limit shows as an extra or missing candidate and a wrong `pos_o` at `done_o`. A misaligned delay line pairs the hash with the wrong candidate, so an expected match never appears, or names the wrong key, `LAT`+1 cycles after that candidate. Errors in priority or stickiness show in `match_idx_o` and `match_cand_o` after overlapping targets are hit in sequence.

// File: rtl/keyenum_pkg.sv
package keyenum_pkg;
  localparam int CHW  = 8;
  localparam int DIGW = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_RUN, ST_DONE} st_e;

  function automatic logic [DIGW-1:0] radix_of(logic alnum);
    return alnum ? 7'd36 : 7'd69;
  endfunction

  function automatic logic [CHW-1:0] sym_of(logic alnum, logic [DIGW-1:0] d);
    logic [CHW-1:0] dx;
    dx = {1'b0, d};
    if (alnum) return (dx < 8'd10) ? 8'h30 + dx : 8'h41 + (dx - 8'd10);
    return (dx < 8'd65) ? 8'h20 + dx : 8'h7B + (dx - 8'd65);
  endfunction
endpackage

// File: rtl/keyenum_ctr.sv
module keyenum_ctr
  import keyenum_pkg::*;
#(
  parameter int NCHAR = 7,
  parameter int OFFW  = 56,
  parameter int WW    = 6
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic                  stop_i,
  input  logic [OFFW-1:0]       offset_i,
  input  logic [WW-1:0]         width_i,
  input  logic                  mode_i,
  output logic                  issue_o,
  output logic [NCHAR*DIGW-1:0] digits_o,
  output logic                  mode_o,
  output logic                  done_o,
  output logic [OFFW-1:0]       pos_o
);
  localparam int LDW  = (NCHAR > 1) ? $clog2(NCHAR) : 1;
  localparam int CNTW = OFFW + 1;

  st_e              st_q;
  logic [DIGW-1:0]  dig_q [NCHAR];
  logic [DIGW-1:0]  dig_nx[NCHAR];
  logic [OFFW-1:0]  rem_q, base_q, rem_div, rad_w;
  logic [DIGW-1:0]  rem_mod, radix;
  logic [LDW-1:0]   ld_q;
  logic [CNTW-1:0]  cnt_q, cnt_inc, lim;
  logic [WW-1:0]    wid_q, wid_clamp;
  logic             mode_q, wrap;

  assign radix     = radix_of(mode_q);
  assign rad_w     = OFFW'(radix);
  assign rem_div   = rem_q / rad_w;
  assign rem_mod   = DIGW'(rem_q % rad_w);
  assign cnt_inc   = cnt_q + 1'b1;
  assign lim       = CNTW'(1) << wid_q;
  assign wid_clamp = (width_i > WW'(OFFW)) ? WW'(OFFW) : width_i;
  assign issue_o   = (st_q == ST_RUN) && !stop_i && !start_i;

  // ripple increment, position 0 first
  always_comb begin
    logic c;
    c = 1'b1;
    for (int i = 0; i < NCHAR; i++) begin
      dig_nx[i] = dig_q[i];
      if (c) begin
        if (dig_q[i] == radix - 1'b1) dig_nx[i] = '0;
        else begin
          dig_nx[i] = dig_q[i] + 1'b1;
          c = 1'b0;
        end
      end
    end
    wrap = c;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      rem_q  <= '0;
      base_q <= '0;
      ld_q   <= '0;
      cnt_q  <= '0;
      wid_q  <= '0;
      mode_q <= 1'b0;
      for (int i = 0; i < NCHAR; i++) dig_q[i] <= '0;
    end else if (start_i) begin
      st_q   <= ST_LOAD;
      rem_q  <= offset_i;
      base_q <= offset_i;
      ld_q   <= '0;
      cnt_q  <= '0;
      wid_q  <= wid_clamp;
      mode_q <= mode_i;
    end else begin
      case (st_q)
        ST_LOAD: begin
          for (int i = 0; i < NCHAR; i++)
            if (LDW'(i) == ld_q) dig_q[i] <= rem_mod;
          rem_q <= rem_div;
          ld_q  <= ld_q + 1'b1;
          if (ld_q == LDW'(NCHAR - 1))
            st_q <= (rem_div == '0) ? ST_RUN : ST_DONE;
        end
        ST_RUN: if (issue_o) begin
          for (int i = 0; i < NCHAR; i++) dig_q[i] <= dig_nx[i];
          cnt_q <= cnt_inc;
          if (wrap || cnt_inc == lim) st_q <= ST_DONE;
        end
        default: ;
      endcase
    end
  end

  for (genvar g = 0; g < NCHAR; g++) begin : g_dig
    assign digits_o[g*DIGW +: DIGW] = dig_q[g];
  end

  assign mode_o = mode_q;
  assign done_o = (st_q == ST_DONE);
  assign pos_o  = base_q + cnt_q[OFFW-1:0];
endmodule

// File: rtl/keyenum_charmap.sv
module keyenum_charmap
  import keyenum_pkg::*;
#(
  parameter int NCHAR = 7
) (
  input  logic                  mode_i,
  input  logic [NCHAR*DIGW-1:0] digits_i,
  output logic [NCHAR*CHW-1:0]  chars_o
);
  for (genvar g = 0; g < NCHAR; g++) begin : g_map
    assign chars_o[g*CHW +: CHW] = sym_of(mode_i, digits_i[g*DIGW +: DIGW]);
  end
endmodule

// File: rtl/keyenum_match.sv
module keyenum_match #(
  parameter int NTGT = 4,
  parameter int KEYW = 56,
  parameter int LAT  = 4,
  parameter int IDXW = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cand_vld_i,
  input  logic [KEYW-1:0]    cand_i,
  input  logic [KEYW-1:0]    hash_i,
  input  logic [NTGT*KEYW-1:0] tgt_i,
  input  logic [NTGT-1:0]    tgt_en_i,
  input  logic               ack_i,
  output logic               match_vld_o,
  output logic [IDXW-1:0]    match_idx_o,
  output logic [KEYW-1:0]    match_cand_o
);
  logic [KEYW-1:0] dc_q [LAT];
  logic [LAT-1:0]  dv_q;
  logic [NTGT-1:0] hit;
  logic            hit_any, fire;
  logic [IDXW-1:0] hit_idx;

  // candidate travels beside its hash
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dv_q <= '0;
      for (int i = 0; i < LAT; i++) dc_q[i] <= '0;
    end else begin
      dv_q[0] <= cand_vld_i;
      dc_q[0] <= cand_i;
      for (int i = 1; i < LAT; i++) begin
        dv_q[i] <= dv_q[i-1];
        dc_q[i] <= dc_q[i-1];
      end
    end
  end

  for (genvar j = 0; j < NTGT; j++) begin : g_cmp
    assign hit[j] = tgt_en_i[j] && (hash_i == tgt_i[j*KEYW +: KEYW]);
  end

  always_comb begin
    hit_any = 1'b0;
    hit_idx = '0;
    for (int j = NTGT - 1; j >= 0; j--) begin
      if (hit[j]) begin
        hit_any = 1'b1;
        hit_idx = IDXW'(j);
      end
    end
  end

  assign fire = dv_q[LAT-1] && hit_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_vld_o  <= 1'b0;
      match_idx_o  <= '0;
      match_cand_o <= '0;
    end else if (fire && (!match_vld_o || ack_i)) begin
      match_vld_o  <= 1'b1;
      match_idx_o  <= hit_idx;
      match_cand_o <= dc_q[LAT-1];
    end else if (ack_i) begin
      match_vld_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/keyspace_enum.sv
module keyspace_enum
  import keyenum_pkg::*;
#(
  parameter int NCHAR = 7,
  parameter int NTGT  = 4,
  parameter int LAT   = 4,
  parameter int WW    = 6,
  localparam int KEYW = NCHAR * CHW,
  localparam int IDXW = (NTGT > 1) ? $clog2(NTGT) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic                 stop_i,
  input  logic [KEYW-1:0]      offset_i,
  input  logic [WW-1:0]        width_i,
  input  logic                 mode_i,
  output logic                 cand_vld_o,
  output logic [KEYW-1:0]      cand_o,
  input  logic [KEYW-1:0]      hash_i,
  input  logic [NTGT*KEYW-1:0] tgt_i,
  input  logic [NTGT-1:0]      tgt_en_i,
  input  logic                 match_ack_i,
  output logic                 match_vld_o,
  output logic [IDXW-1:0]      match_idx_o,
  output logic [KEYW-1:0]      match_cand_o,
  output logic                 done_o,
  output logic [KEYW-1:0]      pos_o
);
  logic                  issue, mode_act;
  logic [NCHAR*DIGW-1:0] digits;
  logic [KEYW-1:0]       chars;

  keyenum_ctr #(.NCHAR(NCHAR), .OFFW(KEYW), .WW(WW)) ctr_i (
    .clk_i, .rst_ni, .start_i, .stop_i, .offset_i, .width_i, .mode_i,
    .issue_o(issue), .digits_o(digits), .mode_o(mode_act),
    .done_o, .pos_o
  );

  keyenum_charmap #(.NCHAR(NCHAR)) map_i (
    .mode_i(mode_act), .digits_i(digits), .chars_o(chars)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cand_vld_o <= 1'b0;
      cand_o     <= '0;
    end else begin
      cand_vld_o <= issue;
      if (issue) cand_o <= chars;
    end
  end

  keyenum_match #(.NTGT(NTGT), .KEYW(KEYW), .LAT(LAT), .IDXW(IDXW)) match_i (
    .clk_i, .rst_ni, .cand_vld_i(cand_vld_o), .cand_i(cand_o), .hash_i,
    .tgt_i, .tgt_en_i, .ack_i(match_ack_i),
    .match_vld_o, .match_idx_o, .match_cand_o
  );
endmodule

// File: rtl/keyspace_enum_chk.sv
module keyspace_enum_chk #(
  parameter int KEYW = 56,
  parameter int IDXW = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            stop_i,
  input logic            cand_vld_o,
  input logic [KEYW-1:0] cand_o,
  input logic            match_ack_i,
  input logic            match_vld_o,
  input logic [IDXW-1:0] match_idx_o,
  input logic [KEYW-1:0] match_cand_o,
  input logic            done_o,
  input logic [KEYW-1:0] pos_o
);
  function automatic logic has_lower(logic [KEYW-1:0] k);
    for (int i = 0; i < KEYW / 8; i++)
      if (k[i*8 +: 8] >= 8'h61 && k[i*8 +: 8] <= 8'h7A) return 1'b1;
    return 1'b0;
  endfunction

  assert_no_lower_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_vld_o |-> !has_lower(cand_o));

  assert_stop_no_issue_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> !cand_vld_o);

  assert_stop_pos_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && !start_i |=> $stable(pos_o));

  assert_sticky_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    match_vld_o && !match_ack_i |=> match_vld_o && $stable(match_idx_o) && $stable(match_cand_o));

  assert_done_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !cand_vld_o);

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);

  assert_pos_step_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cand_vld_o && !start_i && !$past(start_i) |-> pos_o != $past(pos_o));
endmodule

bind keyspace_enum keyspace_enum_chk #(.KEYW(KEYW), .IDXW(IDXW)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .stop_i(stop_i),
  .cand_vld_o(cand_vld_o), .cand_o(cand_o), .match_ack_i(match_ack_i),
  .match_vld_o(match_vld_o), .match_idx_o(match_idx_o),
  .match_cand_o(match_cand_o), .done_o(done_o), .pos_o(pos_o)
);

// File: tb/keyspace_enum_tb_top.sv
`timescale 1ns/1ps
module keyspace_enum_tb_top;
  localparam int LAT  = 4;
  localparam int NTGT = 4;
  localparam int KEYW = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              start, stop, mode, ack;
  logic [KEYW-1:0]   offset;
  logic [5:0]        width;
  logic              cand_vld_o, match_vld_o, done_o;
  logic [KEYW-1:0]   cand_o, hash_in, match_cand_o, pos_o;
  logic [NTGT*KEYW-1:0] tgt;
  logic [NTGT-1:0]   tgt_en;
  logic [1:0]        match_idx_o;

  keyspace_enum #(.NTGT(NTGT), .LAT(LAT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .stop_i(stop),
    .offset_i(offset), .width_i(width), .mode_i(mode),
    .cand_vld_o(cand_vld_o), .cand_o(cand_o), .hash_i(hash_in),
    .tgt_i(tgt), .tgt_en_i(tgt_en), .match_ack_i(ack),
    .match_vld_o(match_vld_o), .match_idx_o(match_idx_o),
    .match_cand_o(match_cand_o), .done_o(done_o), .pos_o(pos_o)
  );

  function automatic logic [KEYW-1:0] hfun(logic [KEYW-1:0] x);
    return {x[47:0], x[55:48]} ^ 56'h5AC3960FE17B24;
  endfunction

  // external hash pipeline model
  logic [KEYW-1:0] hp [LAT];
  always @(posedge clk) begin
    hp[0] <= hfun(cand_o);
    for (int i = 1; i < LAT; i++) hp[i] <= hp[i-1];
  end
  assign hash_in = hp[LAT-1];

  function automatic logic [7:0] exp_sym(logic alnum, longint d);
    if (alnum) return (d < 10) ? 8'(48 + d) : 8'(65 + d - 10);
    return (d < 65) ? 8'(32 + d) : 8'(123 + d - 65);
  endfunction

  function automatic logic [KEYW-1:0] exp_cand(logic alnum, longint idx);
    logic [KEYW-1:0] k;
    longint r, v;
    r = alnum ? 36 : 69;
    v = idx;
    for (int i = 0; i < 7; i++) begin
      k[i*8 +: 8] = exp_sym(alnum, v % r);
      v = v / r;
    end
    return k;
  endfunction

  int checks = 0, errors = 0;
  logic [KEYW-1:0] cap [64];
  int ncap = 0;

  always @(negedge clk)
    if (cand_vld_o && ncap < 64) begin
      cap[ncap] = cand_o;
      ncap++;
    end

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic run(longint off, int w, logic md);
    int t;
    @(negedge clk);
    ncap = 0;
    offset = KEYW'(off);
    width = 6'(w);
    mode = md;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done_o == 1'b0, "R10 start clears done", longint'(done_o), 0);
    t = 0;
    while (!done_o && t < 500) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(cand_vld_o == 0 && done_o == 0 && match_vld_o == 0 && pos_o == 0,
        "R1 reset state", longint'({cand_vld_o, done_o, match_vld_o}), 0);
  endtask

  task automatic t_alnum;
    bit ok;
    run(0, 3, 1'b1);
    chk(ncap == 8, "R5 count width 3", ncap, 8);
    ok = 1;
    for (int k = 0; k < 8; k++) if (cap[k] != exp_cand(1'b1, k)) ok = 0;
    chk(ok, "R1 R2 alnum sequence", longint'(cap[7]), longint'(exp_cand(1'b1, 7)));
    chk(pos_o == 8, "R5 pos after run", longint'(pos_o), 8);
    chk(cap[0] == 56'h30303030303030, "R2 first symbol", longint'(cap[0]), 64'h30303030303030);
    repeat (3) @(negedge clk);
    chk(cand_vld_o == 0 && done_o == 1, "R10 quiet when done", longint'(cand_vld_o), 0);
  endtask

  task automatic t_printable;
    bit ok, low;
    run(40, 5, 1'b0);
    chk(ncap == 32, "R5 count width 5", ncap, 32);
    ok = 1; low = 0;
    for (int k = 0; k < 32; k++) begin
      if (cap[k] != exp_cand(1'b0, 40 + k)) ok = 0;
      for (int b = 0; b < 7; b++)
        if (cap[k][b*8 +: 8] >= 8'h61 && cap[k][b*8 +: 8] <= 8'h7A) low = 1;
    end
    chk(ok, "R3 printable sequence", longint'(cap[28]), longint'(exp_cand(1'b0, 68)));
    chk(!low, "R3 no lowercase", longint'(low), 0);
    chk(cap[29] == 56'h20202020202120, "R3 carry past 0x7E", longint'(cap[29]), 64'h20202020202120);
  endtask

  task automatic t_partition;
    bit ok;
    run(4, 2, 1'b1);
    chk(ncap == 4, "R4 partition count", ncap, 4);
    ok = 1;
    for (int k = 0; k < 4; k++) if (cap[k] != exp_cand(1'b1, 4 + k)) ok = 0;
    chk(ok, "R4 offset start", longint'(cap[0]), longint'(exp_cand(1'b1, 4)));
    chk(pos_o == 8, "R4 pos resume value", longint'(pos_o), 8);
  endtask

  task automatic t_stop;
    logic [KEYW-1:0] p;
    bit ok;
    @(negedge clk);
    ncap = 0;
    offset = '0; width = 6'd4; mode = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (11) @(negedge clk);
    stop = 1'b1;
    repeat (2) @(negedge clk);
    p = pos_o;
    chk(cand_vld_o == 0, "R6 no issue while stopped", longint'(cand_vld_o), 0);
    repeat (3) @(negedge clk);
    chk(pos_o == p && cand_vld_o == 0, "R6 pos frozen", longint'(pos_o), longint'(p));
    stop = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(ncap == 16, "R6 total after resume", ncap, 16);
    ok = 1;
    for (int k = 0; k < 16; k++) if (cap[k] != exp_cand(1'b1, k)) ok = 0;
    chk(ok, "R6 contiguous after resume", longint'(cap[15]), longint'(exp_cand(1'b1, 15)));
  endtask

  task automatic t_wrap;
    longint full;
    full = 1;
    for (int i = 0; i < 7; i++) full = full * 36;
    run(full - 2, 5, 1'b1);
    chk(ncap == 2, "R5 stop at wrap", ncap, 2);
    chk(cap[1] == exp_cand(1'b1, full - 1), "R5 last key", longint'(cap[1]), longint'(exp_cand(1'b1, full - 1)));
    chk(pos_o == KEYW'(full), "R5 pos at wrap", longint'(pos_o), full);
    run(full, 3, 1'b1);
    chk(ncap == 0 && done_o == 1, "R4 offset out of range", ncap, 0);
  endtask

  task automatic t_match;
    tgt = '0;
    tgt[0*KEYW +: KEYW] = hfun(exp_cand(1'b1, 5));
    tgt[1*KEYW +: KEYW] = hfun(exp_cand(1'b1, 3));
    tgt[2*KEYW +: KEYW] = hfun(exp_cand(1'b1, 1));
    tgt[3*KEYW +: KEYW] = hfun(exp_cand(1'b1, 3));
    tgt_en = 4'b1011;
    run(0, 3, 1'b1);
    repeat (LAT + 2) @(negedge clk);
    chk(match_vld_o == 1, "R7 match reported", longint'(match_vld_o), 1);
    chk(match_idx_o == 1, "R8 lowest index", longint'(match_idx_o), 1);
    chk(match_cand_o == exp_cand(1'b1, 3), "R7 R9 candidate kept", longint'(match_cand_o), longint'(exp_cand(1'b1, 3)));
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    chk(match_vld_o == 0, "R9 ack clears", longint'(match_vld_o), 0);
    run(4, 2, 1'b1);
    repeat (LAT + 2) @(negedge clk);
    chk(match_vld_o == 1 && match_idx_o == 0, "R7 second match index", longint'(match_idx_o), 0);
    chk(match_cand_o == exp_cand(1'b1, 5), "R7 second match cand", longint'(match_cand_o), longint'(exp_cand(1'b1, 5)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    start = 0; stop = 0; mode = 0; ack = 0; offset = '0; width = '0;
    tgt = '0; tgt_en = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_alnum();
    t_printable();
    t_partition();
    t_stop();
    t_wrap();
    t_match();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule